// File: doc/BRIEF.md
# Selectable Hardware/Software Clock Gate

This block gates one clock under control of a single 32-bit control and status word, written and read over a plain register port. The word carries three live fields: a software enable, a mode select that hands the gate to either the software enable or an external hardware request line, and a read-only status flag. The status flag follows the actual gate state through a two-stage synchronizer. Software can therefore write a new setting and poll until the gate has really switched.

The gating cell is a latch that is transparent during the low phase of the clock, followed by an AND. The enable can only change while the clock is low, so the gated output never carries a shortened pulse. A build-time parameter picks one of three gate kinds. The full gate honours the software enable. The no-disable gate always runs while in software mode. The absent gate is a clock that is never stopped.

In hardware mode the gate opens as soon as the request input is seen high during a low clock phase. It stays open for one further clock after the request drops, so a request that lasts one cycle lets two gated pulses through.

Top module: `clk_gate_ctrl`

## Requirements
- R1: After reset the gate is in software mode with the enable set, the word reads 0x7 and the gated clock runs.
- R2: Word layout: bit 0 is the enable (1 = run), bit 1 is the mode select (1 = software, 0 = hardware request) and bit 2 is the read-only status. Bits 31..3 read 0. Writes to bit 2 and to bits 31..3 have no effect. Bits 0 and 1 hold their value while no write occurs.
- R3: Full gate kind in software mode: the gated clock runs exactly when bit 0 is 1.
- R4: Hardware mode: the gated clock runs while hw_req_i is high. A request held for one clock cycle produces exactly two gated pulses.
- R5: In hardware mode the enable bit has no effect on the gated clock.
- R6: The status bit shows the gate state of a write two clock edges after the edge that captured the write. After one edge it still reads the old state.
- R7: The status bit reports the gate state in hardware mode as well. It is 1 while the request is held and 0 after the request has been low for several cycles.
- R8: No-disable gate kind: in software mode the gated clock runs whatever bit 0 holds. In hardware mode it behaves as in R4.
- R9: Absent gate kind: the gated clock always runs and the status bit always reads 1.
- R10: The gated clock rises only at a rising edge of clk_i and falls only at a falling edge of clk_i, even when hw_req_i changes during the high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Write strobe for the control word |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Control word read-back, including status |
| hw_req_i | input | 1 | Hardware request that opens the gate in hardware mode |
| gclk_o | output | 1 | Gated clock |

## Verification
The bench sweeps every combination of mode, enable and request on all three gate kinds side by side. It counts gated pulses in fixed windows. A kind that ignored its variant, for example a no-disable gate that stops, shows the wrong count at once.

Status lag is sampled one edge and two edges after a write. A design that reports the requested state instead of the synchronized gate state flips too early.

A one-cycle hardware request must give exactly two pulses. A missing or extra hold stage changes that count.

The request line is toggled in the middle of the high phase. A design that ANDs the enable straight onto the clock, without the latch, then produces edges away from the source edges, and the bench flags them.

// File: rtl/cg_pkg.sv
`timescale 1ns/1ps
package cg_pkg;
  typedef enum logic [1:0] {
    CG_KIND_FULL   = 2'd0,
    CG_KIND_NO_OFF = 2'd1,
    CG_KIND_ABSENT = 2'd2
  } cg_kind_e;

  localparam int unsigned CG_EN_POS  = 0;
  localparam int unsigned CG_SEL_POS = 1;
  localparam int unsigned CG_STS_POS = 2;

  typedef struct packed {
    logic sw_sel;
    logic en;
  } cg_ctrl_t;
endpackage

// File: rtl/cg_ctrl_reg.sv
`timescale 1ns/1ps
module cg_ctrl_reg
  import cg_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          sts_i,
  output cg_ctrl_t      ctrl_o,
  output logic [DW-1:0] rdata_o
);
  cg_ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q.sw_sel <= 1'b1;
      ctrl_q.en     <= 1'b1;
    end else if (wr_i) begin
      ctrl_q.sw_sel <= wdata_i[CG_SEL_POS];
      ctrl_q.en     <= wdata_i[CG_EN_POS];
    end
  end

  always_comb begin
    rdata_o             = '0;
    rdata_o[CG_EN_POS]  = ctrl_q.en;
    rdata_o[CG_SEL_POS] = ctrl_q.sw_sel;
    rdata_o[CG_STS_POS] = sts_i;
  end

  assign ctrl_o = ctrl_q;

  assert_hold_without_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(ctrl_q));
endmodule

// File: rtl/cg_hw_hold.sv
`timescale 1ns/1ps
module cg_hw_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic open_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= req_i;
  end

  // open at once, close one cycle after the request drops
  assign open_o = req_i | req_q;

  assert_hold_after_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_i) |-> open_o);
endmodule

// File: rtl/cg_gate_cell.sv
`timescale 1ns/1ps
module cg_gate_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic en_lat_o,
  output logic gclk_o
);
  logic en_lat;

  // transparent while clock is low
  always_latch begin
    if (!rst_ni)     en_lat = 1'b1;
    else if (!clk_i) en_lat = en_i;
  end

  assign en_lat_o = en_lat;
  assign gclk_o   = clk_i & en_lat;
endmodule

// File: rtl/cg_status_sync.sv
`timescale 1ns/1ps
module cg_status_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= 1'b1;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/clk_gate_ctrl.sv
`timescale 1ns/1ps
module clk_gate_ctrl
  import cg_pkg::*;
#(
  parameter cg_kind_e    GATE_KIND   = CG_KIND_FULL,
  parameter int unsigned DW          = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          hw_req_i,
  output logic          gclk_o
);
  cg_ctrl_t ctrl;
  logic     hw_open;
  logic     want_open;
  logic     en_lat;
  logic     sts;

  cg_ctrl_reg #(.DW(DW)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .wdata_i (reg_wdata_i),
    .sts_i   (sts),
    .ctrl_o  (ctrl),
    .rdata_o (reg_rdata_o)
  );

  cg_hw_hold u_hw (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (hw_req_i),
    .open_o (hw_open)
  );

  always_comb begin
    case (GATE_KIND)
      CG_KIND_NO_OFF: want_open = ctrl.sw_sel | hw_open;
      CG_KIND_ABSENT: want_open = 1'b1;
      default:        want_open = ctrl.sw_sel ? ctrl.en : hw_open;
    endcase
  end

  cg_gate_cell u_cell (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (want_open),
    .en_lat_o (en_lat),
    .gclk_o   (gclk_o)
  );

  cg_status_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (en_lat),
    .q_o    (sts)
  );

  if (GATE_KIND == CG_KIND_FULL && SYNC_STAGES == 2) begin : g_chk
    assert_sw_off_status_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl.sw_sel && !ctrl.en && $past(ctrl.sw_sel && !ctrl.en)
       && $past(ctrl.sw_sel && !ctrl.en, 2)) |-> !reg_rdata_o[CG_STS_POS]);
    assert_sw_on_status_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl.sw_sel && ctrl.en && $past(ctrl.sw_sel && ctrl.en)
       && $past(ctrl.sw_sel && ctrl.en, 2)) |-> reg_rdata_o[CG_STS_POS]);
    assert_hw_idle_status_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ctrl.sw_sel && $past(!ctrl.sw_sel) && $past(!ctrl.sw_sel, 2)
       && !$past(hw_req_i) && !$past(hw_req_i, 2) && !$past(hw_req_i, 3))
      |-> !reg_rdata_o[CG_STS_POS]);
  end

  if (GATE_KIND == CG_KIND_ABSENT) begin : g_chk_abs
    assert_absent_status_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reg_rdata_o[CG_STS_POS]);
  end
endmodule

// File: tb/tb_clk_gate_ctrl.sv
`timescale 1ns/1ps
module tb_clk_gate_ctrl;
  import cg_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic        hw_req = 1'b0;
  logic [31:0] rd_f, rd_n, rd_a;
  logic        gclk_f, gclk_n, gclk_a;

  int vectors = 0;
  int miscompares = 0;
  int cnt_f = 0, cnt_n = 0, cnt_a = 0;
  int runts = 0;

  always #4 clk = ~clk;

  clk_gate_ctrl #(.GATE_KIND(CG_KIND_FULL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rd_f), .hw_req_i(hw_req), .gclk_o(gclk_f));
  clk_gate_ctrl #(.GATE_KIND(CG_KIND_NO_OFF)) dut_nd (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rd_n), .hw_req_i(hw_req), .gclk_o(gclk_n));
  clk_gate_ctrl #(.GATE_KIND(CG_KIND_ABSENT)) dut_ab (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rd_a), .hw_req_i(hw_req), .gclk_o(gclk_a));

  always @(posedge gclk_f) cnt_f++;
  always @(posedge gclk_n) cnt_n++;
  always @(posedge gclk_a) cnt_a++;

  // R10: gated edges must coincide with source edges (rise at t%8==4, fall at t%8==0)
  always @(posedge gclk_f) if (rst_n && ($time % 8) != 4) runts++;
  always @(negedge gclk_f) if (rst_n && ($time % 8) != 0) runts++;
  always @(posedge gclk_n) if (rst_n && ($time % 8) != 4) runts++;
  always @(negedge gclk_n) if (rst_n && ($time % 8) != 0) runts++;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr_reg(input logic [31:0] d);
    @(negedge clk); #1;
    wr = 1'b1; wdata = d;
    @(negedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic measure(input int n);
    cnt_f = 0; cnt_n = 0; cnt_a = 0;
    step(n);
  endtask

  initial begin
    #(8 * 150000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    step(5);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 word", int'(rd_f), 7);
    measure(8);
    chk("R1 pulses", cnt_f, 8);

    // sweep mode x enable x request on all kinds
    for (int sel = 0; sel < 2; sel++) begin
      for (int en = 0; en < 2; en++) begin
        for (int rq = 0; rq < 2; rq++) begin
          int ef, en_exp;
          hw_req = rq[0];
          wr_reg({30'b0, sel[0], en[0]});
          step(4);
          measure(8);
          ef     = sel ? en * 8 : rq * 8;
          en_exp = sel ? 8 : rq * 8;
          if (sel == 1) chk("R3 sw full pulses", cnt_f, ef);
          else          chk("R5 hw full pulses ignore en", cnt_f, ef);
          chk("R8 no-disable pulses", cnt_n, en_exp);
          chk("R9 absent pulses", cnt_a, 8);
          chk("R9 absent status", int'(rd_a[2]), 1);
          chk("R7 full status", int'(rd_f[2]), (ef > 0) ? 1 : 0);
          chk("R2 fields", int'(rd_f[1:0]), sel * 2 + en);
          chk("R2 upper zero", int'(rd_f[31:3]), 0);
        end
      end
    end

    // R2 writes to status/upper bits ignored
    hw_req = 1'b0;
    wr_reg(32'hFFFF_FFFC);
    step(4);
    chk("R2 ignored status write", int'(rd_f[2]), 0);
    chk("R2 ignored upper write", int'(rd_f[31:3]), 0);
    chk("R2 mode field", int'(rd_f[1:0]), 0);

    // R6 status lag
    wr_reg(32'h3);
    step(4);
    wr_reg(32'h2);
    chk("R6 lag edge0", int'(rd_f[2]), 1);
    step(1);
    chk("R6 lag edge1", int'(rd_f[2]), 1);
    step(1);
    chk("R6 lag edge2", int'(rd_f[2]), 0);
    wr_reg(32'h3);
    chk("R6 lag on edge0", int'(rd_f[2]), 0);
    step(1);
    chk("R6 lag on edge1", int'(rd_f[2]), 0);
    step(1);
    chk("R6 lag on edge2", int'(rd_f[2]), 1);

    // R4 one-cycle request -> two pulses
    wr_reg(32'h1);
    step(4);
    cnt_f = 0; cnt_n = 0;
    hw_req = 1'b1;
    step(1);
    hw_req = 1'b0;
    step(5);
    chk("R4 one-cycle request full", cnt_f, 2);
    chk("R8 one-cycle request no-disable", cnt_n, 2);

    // R7 status tracks held request then release
    hw_req = 1'b1;
    step(5);
    chk("R7 status with request", int'(rd_f[2]), 1);
    hw_req = 1'b0;
    step(5);
    chk("R7 status after release", int'(rd_f[2]), 0);

    // R10 request toggled mid high phase
    runts = 0;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #2;
      hw_req = ~hw_req;
    end
    hw_req = 1'b0;
    step(4);
    chk("R10 no runt edges", runts, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule